// File: doc/BRIEF.md
# Scan Test Vector Sequencer

This block runs a stored set of combinational test patterns through one scan chain of a design under test. For each pattern it serially loads the present-state bits while the chain is in shift mode, then gives a single functional clock with the pattern's primary-input bits applied, so the flip-flops capture their next state. The captured state is shifted out while the next pattern's state is shifted in. After the last pattern, one more chain-length of shift cycles, fed with zero filler, unloads the final response. A complete run lasts (NUM_VEC + 1) x CHAIN_LEN + NUM_VEC clock cycles.

Patterns are written beforehand through a simple write port. Each entry holds the state to load, the primary inputs to apply, the expected captured state and the expected primary outputs. The block compares the primary outputs on each capture cycle and every unloaded scan bit with the expected values. It counts the patterns that show at least one mismatch, keeps a sticky fail flag, and pulses a done output when the last unloaded bit has been judged.

Top module: `scan_seq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, tst_mode is 1 (functional mode), and busy, done, fail and fail_count are all 0. Whenever the block is idle, tst_mode stays 1.
- R2: A start pulse sampled while idle begins a run. busy is high for exactly (NUM_VEC+1)*CHAIN_LEN+NUM_VEC consecutive cycles, starting in the cycle after the start edge. done is high for exactly one cycle, the cycle right after the last busy cycle.
- R3: Cycle c of a run is numbered from 0. Pattern v is loaded in cycles v*(CHAIN_LEN+1)+k, for k = 0..CHAIN_LEN-1. In those cycles tst_mode is 0 (shift mode) and scan_in carries bit CHAIN_LEN-1-k of the pattern's state word, so the most significant bit goes first.
- R4: Cycle v*(CHAIN_LEN+1)+CHAIN_LEN is the single capture cycle of pattern v. In it, tst_mode is 1, pi_drive equals the pattern's input word and scan_in is 0. In every other cycle, pi_drive is 0.
- R5: The final CHAIN_LEN cycles of a run are shift cycles with scan_in held at 0.
- R6: po_obs is compared with the pattern's expected output word on its capture cycle.
- R7: During the CHAIN_LEN shift cycles that follow the capture of pattern v, scan_out in the k-th of those cycles is compared with bit CHAIN_LEN-1-k of the pattern's expected state. The chain is modelled as flop 0 fed by scan_in, with scan_out taken from flop CHAIN_LEN-1.
- R8: fail_count is the number of patterns with at least one output or scan-bit mismatch, and each pattern counts at most once. fail is 1 exactly when fail_count is nonzero. Both values are valid while done is high, persist after the run, and are cleared when the next run starts.
- R9: A start pulse during a run has no effect on the run's timing, drive values or result.
- R10: Reset during a run returns the block to idle at once with tst_mode 1, and no done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| wr_en | input | 1 | Pattern store write strobe |
| wr_addr | input | AW | Pattern index to write |
| wr_state | input | CHAIN_LEN | Present state to load |
| wr_pi | input | PI_W | Primary inputs for the capture cycle |
| wr_exp_state | input | CHAIN_LEN | Expected captured state |
| wr_exp_po | input | PO_W | Expected primary outputs |
| tst_mode | output | 1 | 0 = shift mode, 1 = functional mode |
| scan_in | output | 1 | Serial chain input |
| pi_drive | output | PI_W | Primary inputs applied to the design |
| scan_out | input | 1 | Serial chain output |
| po_obs | input | PO_W | Observed primary outputs |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sticky mismatch flag |
| fail_count | output | CW | Number of failing patterns |

## Verification
The bench runs a behavioural scan-inserted circuit next to the block and steps through two pattern tables. One table has mixed state words. The other has all-zero and all-one states, which exposes bit-order and filler mistakes that random-looking data can hide. A clean circuit must give a zero count. A stuck primary output tests the capture-cycle compare. A stuck capture flop tests the serial unload compare and the alignment of each unloaded bit. A single corrupted expected entry must give a count of exactly one, which separates per-pattern counting from per-bit counting. A mid-run start and a mid-run reset check that the run timeline cannot be disturbed and can be cleanly aborted.

// File: rtl/scan_seq_pkg.sv
// Shared types for the scan test vector sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package scan_seq_pkg;

    // Run phases of the sequencer
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // waiting for start, functional mode
        PH_SHIFT = 2'd1,   // loading a pattern (and unloading the previous one)
        PH_CAPT  = 2'd2,   // single functional capture clock
        PH_FLUSH = 2'd3    // unloading the last response with zero filler
    } seq_phase_t;

endpackage

// File: rtl/scan_vec_store.sv
// Pattern storage: one register array per field, one write port,
// a load-side read port (pattern being shifted in / captured) and a
// check-side read port (pattern whose response is being unloaded).
// Assumes: writes happen while the sequencer is idle; no reset on contents.
module scan_vec_store #(
    parameter int CHAIN_LEN = 4,
    parameter int NUM_VEC   = 4,
    parameter int PI_W      = 3,
    parameter int PO_W      = 2,
    parameter int AW        = 2
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [CHAIN_LEN-1:0] wr_state,
    input  logic [PI_W-1:0]      wr_pi,
    input  logic [CHAIN_LEN-1:0] wr_exp_state,
    input  logic [PO_W-1:0]      wr_exp_po,
    input  logic [AW-1:0]        ld_idx,
    input  logic [AW-1:0]        chk_idx,
    output logic [CHAIN_LEN-1:0] ld_state,
    output logic [PI_W-1:0]      ld_pi,
    output logic [PO_W-1:0]      ld_exp_po,
    output logic [CHAIN_LEN-1:0] chk_exp_state
);

    logic [CHAIN_LEN-1:0] mem_state     [NUM_VEC];
    logic [PI_W-1:0]      mem_pi        [NUM_VEC];
    logic [CHAIN_LEN-1:0] mem_exp_state [NUM_VEC];
    logic [PO_W-1:0]      mem_exp_po    [NUM_VEC];

    // Write one pattern entry; out-of-range addresses are dropped
    always_ff @(posedge clk) begin
        if (wr_en && (int'(wr_addr) < NUM_VEC)) begin
            mem_state[wr_addr]     <= wr_state;
            mem_pi[wr_addr]        <= wr_pi;
            mem_exp_state[wr_addr] <= wr_exp_state;
            mem_exp_po[wr_addr]    <= wr_exp_po;
        end
    end

    // Asynchronous read of the pattern being loaded or captured
    always_comb begin
        ld_state  = mem_state[ld_idx];
        ld_pi     = mem_pi[ld_idx];
        ld_exp_po = mem_exp_po[ld_idx];
    end

    // Asynchronous read of the expected state being unloaded
    always_comb begin
        chk_exp_state = mem_exp_state[chk_idx];
    end

endmodule

// File: rtl/scan_seq_fsm.sv
// Run sequencer: walks shift / capture / flush phases with a bit counter
// and a pattern counter, and remembers which pattern's response is in
// the chain. Start is only honoured in idle.
// Assumes: CHAIN_LEN >= 1 and NUM_VEC >= 1.
module scan_seq_fsm
    import scan_seq_pkg::*;
#(
    parameter int CHAIN_LEN = 4,
    parameter int NUM_VEC   = 4,
    parameter int AW        = 2,
    parameter int BW        = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output seq_phase_t    phase,
    output logic [BW-1:0] bit_idx,
    output logic [AW-1:0] vec_idx,
    output logic [AW-1:0] chk_idx,
    output logic          run_go,
    output logic          capture,
    output logic          check_shift,
    output logic          last_bit,
    output logic          final_bit
);

    localparam logic [BW-1:0] BIT_LAST = BW'(CHAIN_LEN - 1);
    localparam logic [AW-1:0] VEC_LAST = AW'(NUM_VEC - 1);

    seq_phase_t    phase_q;
    logic [BW-1:0] bit_q;
    logic [AW-1:0] vec_q;
    logic [AW-1:0] chk_q;

    // Decode of the current phase for the datapath and checker
    always_comb begin
        run_go      = (phase_q == PH_IDLE) && start;
        capture     = (phase_q == PH_CAPT);
        check_shift = ((phase_q == PH_SHIFT) && (vec_q != '0)) ||
                      (phase_q == PH_FLUSH);
        last_bit    = (bit_q == BIT_LAST);
        final_bit   = (phase_q == PH_FLUSH) && (bit_q == BIT_LAST);
    end

    // Phase, bit and pattern counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            bit_q   <= '0;
            vec_q   <= '0;
            chk_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q <= PH_SHIFT;
                        bit_q   <= '0;
                        vec_q   <= '0;
                    end
                end
                PH_SHIFT: begin
                    if (bit_q == BIT_LAST) begin
                        phase_q <= PH_CAPT;
                        bit_q   <= '0;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                    end
                end
                PH_CAPT: begin
                    chk_q <= vec_q;
                    bit_q <= '0;
                    if (vec_q == VEC_LAST) begin
                        phase_q <= PH_FLUSH;
                    end else begin
                        phase_q <= PH_SHIFT;
                        vec_q   <= vec_q + 1'b1;
                    end
                end
                PH_FLUSH: begin
                    if (bit_q == BIT_LAST) begin
                        phase_q <= PH_IDLE;
                        bit_q   <= '0;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase   = phase_q;
    assign bit_idx = bit_q;
    assign vec_idx = vec_q;
    assign chk_idx = chk_q;

endmodule

// File: rtl/scan_resp_check.sv
// Response comparator: judges primary outputs on each capture cycle and
// each unloaded scan bit, folds them into a per-pattern error bit and,
// when the pattern's last bit is judged, counts it as failing at most once.
// Assumes: capture and unload of consecutive patterns never share a cycle.
module scan_resp_check #(
    parameter int PO_W = 2,
    parameter int CW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_go,
    input  logic            capture,
    input  logic [PO_W-1:0] exp_po,
    input  logic [PO_W-1:0] po_obs,
    input  logic            check_shift,
    input  logic            last_bit,
    input  logic            final_bit,
    input  logic            scan_out,
    input  logic            exp_bit,
    output logic            fail,
    output logic [CW-1:0]   fail_count,
    output logic            done
);

    logic          err_acc;
    logic          po_miss;
    logic          bit_miss;
    logic          fail_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;

    // Mismatch detection for the current cycle
    always_comb begin
        po_miss  = capture && (po_obs != exp_po);
        bit_miss = check_shift && (scan_out != exp_bit);
    end

    // Per-pattern accumulation, failing-pattern count, sticky flag, done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_acc <= 1'b0;
            fail_q  <= 1'b0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else if (run_go) begin
            err_acc <= 1'b0;
            fail_q  <= 1'b0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= final_bit;
            if (capture) begin
                err_acc <= po_miss;
            end else if (check_shift) begin
                if (last_bit) begin
                    if (err_acc || bit_miss) begin
                        cnt_q  <= cnt_q + 1'b1;
                        fail_q <= 1'b1;
                    end
                    err_acc <= 1'b0;
                end else begin
                    err_acc <= err_acc || bit_miss;
                end
            end
        end
    end

    assign fail       = fail_q;
    assign fail_count = cnt_q;
    assign done       = done_q;

endmodule

// File: rtl/scan_seq_ctrl.sv
// Top of the scan test vector sequencer. Drives the test-mode line, the
// serial chain input and the primary inputs of the design under test from
// stored patterns, and checks scan_out and po_obs against stored responses.
// Assumes: scan_out and po_obs are combinational views of the design's
// last chain flop and outputs in the same cycle; patterns written while idle.
module scan_seq_ctrl
    import scan_seq_pkg::*;
#(
    parameter int CHAIN_LEN = 4,
    parameter int NUM_VEC   = 4,
    parameter int PI_W      = 3,
    parameter int PO_W      = 2,
    parameter int AW        = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
    parameter int CW        = $clog2(NUM_VEC + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [CHAIN_LEN-1:0] wr_state,
    input  logic [PI_W-1:0]      wr_pi,
    input  logic [CHAIN_LEN-1:0] wr_exp_state,
    input  logic [PO_W-1:0]      wr_exp_po,
    output logic                 tst_mode,
    output logic                 scan_in,
    output logic [PI_W-1:0]      pi_drive,
    input  logic                 scan_out,
    input  logic [PO_W-1:0]      po_obs,
    output logic                 busy,
    output logic                 done,
    output logic                 fail,
    output logic [CW-1:0]        fail_count
);

    localparam int BW = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
    localparam logic [BW-1:0] MSB_SEL = BW'(CHAIN_LEN - 1);

    seq_phase_t           phase;
    logic [BW-1:0]        bit_idx;
    logic [AW-1:0]        vec_idx;
    logic [AW-1:0]        chk_idx;
    logic                 run_go;
    logic                 capture;
    logic                 check_shift;
    logic                 last_bit;
    logic                 final_bit;
    logic [CHAIN_LEN-1:0] ld_state;
    logic [PI_W-1:0]      ld_pi;
    logic [PO_W-1:0]      ld_exp_po;
    logic [CHAIN_LEN-1:0] chk_exp_state;
    logic [BW-1:0]        bit_sel;
    logic                 exp_bit;

    scan_vec_store #(
        .CHAIN_LEN(CHAIN_LEN), .NUM_VEC(NUM_VEC),
        .PI_W(PI_W), .PO_W(PO_W), .AW(AW)
    ) u_store (
        .clk          (clk),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_state     (wr_state),
        .wr_pi        (wr_pi),
        .wr_exp_state (wr_exp_state),
        .wr_exp_po    (wr_exp_po),
        .ld_idx       (vec_idx),
        .chk_idx      (chk_idx),
        .ld_state     (ld_state),
        .ld_pi        (ld_pi),
        .ld_exp_po    (ld_exp_po),
        .chk_exp_state(chk_exp_state)
    );

    scan_seq_fsm #(
        .CHAIN_LEN(CHAIN_LEN), .NUM_VEC(NUM_VEC), .AW(AW), .BW(BW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .phase      (phase),
        .bit_idx    (bit_idx),
        .vec_idx    (vec_idx),
        .chk_idx    (chk_idx),
        .run_go     (run_go),
        .capture    (capture),
        .check_shift(check_shift),
        .last_bit   (last_bit),
        .final_bit  (final_bit)
    );

    // Most-significant-first bit selection shared by load and unload
    always_comb begin
        bit_sel = MSB_SEL - bit_idx;
        exp_bit = chk_exp_state[bit_sel];
    end

    // Drive values towards the design under test
    always_comb begin
        tst_mode = !((phase == PH_SHIFT) || (phase == PH_FLUSH));
        scan_in  = (phase == PH_SHIFT) ? ld_state[bit_sel] : 1'b0;
        pi_drive = capture ? ld_pi : '0;
        busy     = (phase != PH_IDLE);
    end

    scan_resp_check #(
        .PO_W(PO_W), .CW(CW)
    ) u_check (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_go     (run_go),
        .capture    (capture),
        .exp_po     (ld_exp_po),
        .po_obs     (po_obs),
        .check_shift(check_shift),
        .last_bit   (last_bit),
        .final_bit  (final_bit),
        .scan_out   (scan_out),
        .exp_bit    (exp_bit),
        .fail       (fail),
        .fail_count (fail_count),
        .done       (done)
    );

endmodule

// File: rtl/scan_seq_checker.sv
// Property checker for scan_seq_ctrl, attached by bind. Tracks the cycle
// index within a run with its own counter so that window checks need no
// long $past chains.
// Assumes: bound into scan_seq_ctrl with matching parameters.
module scan_seq_checker #(
    parameter int CHAIN_LEN = 4,
    parameter int NUM_VEC   = 4,
    parameter int PI_W      = 3,
    parameter int CW        = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            tst_mode,
    input logic            scan_in,
    input logic [PI_W-1:0] pi_drive,
    input logic            done,
    input logic            fail,
    input logic [CW-1:0]   fail_count
);

    localparam int TOTAL    = (NUM_VEC + 1) * CHAIN_LEN + NUM_VEC;
    localparam int FLUSH_AT = NUM_VEC * (CHAIN_LEN + 1);
    localparam int CNTW     = $clog2(TOTAL + 1) + 1;

    logic [CNTW-1:0] run_cnt;

    // Count busy cycles of the current run
    always_ff @(posedge clk) begin
        if (!rst_n)    run_cnt <= '0;
        else if (busy) run_cnt <= run_cnt + 1'b1;
        else           run_cnt <= '0;
    end

    AST_IDLE_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tst_mode);                                               // R1
    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && run_cnt == CNTW'(TOTAL)));                      // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                   // R2
    AST_CAPTURE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tst_mode) |=> (busy && !tst_mode));                       // R4
    AST_PI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy || !tst_mode) |-> (pi_drive == '0));                        // R4
    AST_FLUSH_FILLER: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run_cnt >= CNTW'(FLUSH_AT)) |-> (!tst_mode && !scan_in)); // R5
    AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (fail_count == '0 && !fail));                      // R8
    AST_FAIL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fail == (fail_count != '0)));                            // R8
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fail_count) <= NUM_VEC);                                      // R8

endmodule

bind scan_seq_ctrl scan_seq_checker #(
    .CHAIN_LEN(CHAIN_LEN), .NUM_VEC(NUM_VEC), .PI_W(PI_W), .CW(CW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .tst_mode  (tst_mode),
    .scan_in   (scan_in),
    .pi_drive  (pi_drive),
    .done      (done),
    .fail      (fail),
    .fail_count(fail_count)
);

// File: tb/tb_scan_seq_ctrl.sv
// Bench: a behavioural scan-inserted circuit (4 chain flops, 3 inputs,
// 2 outputs) is driven by the sequencer; the run timeline and the fail
// result are predicted from the requirements.
module tb_scan_seq_ctrl;

    localparam int N    = 4;
    localparam int V    = 4;
    localparam int PIW  = 3;
    localparam int POW  = 2;
    localparam int AW   = 2;
    localparam int CW   = 3;
    localparam int T    = (V + 1) * N + V;

    // Pattern tables: {state[3:0], pi[2:0]}
    localparam logic [6:0] TAB_A [V] = '{7'b1011_010, 7'b0110_101, 7'b1111_000, 7'b0001_111};
    localparam logic [6:0] TAB_B [V] = '{7'b0000_000, 7'b1111_111, 7'b0000_101, 7'b1111_010};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [N-1:0] wr_state = '0;
    logic [PIW-1:0] wr_pi = '0;
    logic [N-1:0] wr_exp_state = '0;
    logic [POW-1:0] wr_exp_po = '0;
    logic tst_mode, scan_in, busy, done, fail;
    logic [PIW-1:0] pi_drive;
    logic [CW-1:0] fail_count;
    logic scan_out;
    logic [POW-1:0] po_obs;

    logic [N-1:0] cut_q;
    bit flt_po = 1'b0;
    bit flt_ff = 1'b0;

    logic [N-1:0]   cur_state [V];
    logic [PIW-1:0] cur_pi    [V];

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    scan_seq_ctrl #(.CHAIN_LEN(N), .NUM_VEC(V), .PI_W(PIW), .PO_W(POW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_state(wr_state), .wr_pi(wr_pi),
        .wr_exp_state(wr_exp_state), .wr_exp_po(wr_exp_po),
        .tst_mode(tst_mode), .scan_in(scan_in), .pi_drive(pi_drive),
        .scan_out(scan_out), .po_obs(po_obs),
        .busy(busy), .done(done), .fail(fail), .fail_count(fail_count)
    );

    function automatic logic [N-1:0] f_next(input logic [N-1:0] s, input logic [PIW-1:0] p, input bit flt);
        logic [N-1:0] r;
        r = {s[2:0], s[3]} ^ {1'b0, p};
        if (flt) r[2] = 1'b1;
        return r;
    endfunction

    function automatic logic [POW-1:0] g_po(input logic [N-1:0] s, input logic [PIW-1:0] p, input bit flt);
        logic [POW-1:0] r;
        r = {(^s) ^ p[2], s[3] | p[1]};
        if (flt) r[0] = 1'b0;
        return r;
    endfunction

    // Circuit under test: chain flop 0 fed by scan_in, scan_out from flop 3
    always_ff @(posedge clk) begin
        if (!tst_mode) cut_q <= {cut_q[N-2:0], scan_in};
        else           cut_q <= f_next(cut_q, pi_drive, flt_ff);
    end
    assign scan_out = cut_q[N-1];
    assign po_obs   = g_po(cut_q, pi_drive, flt_po);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Walk a table, writing every pattern; one entry can get a wrong expected PO
    task automatic load_table(input bit use_b, input int corrupt);
        for (int i = 0; i < V; i++) begin
            logic [6:0] e;
            e = use_b ? TAB_B[i] : TAB_A[i];
            cur_state[i] = e[6:3];
            cur_pi[i]    = e[2:0];
            @(negedge clk);
            wr_en        = 1'b1;
            wr_addr      = AW'(i);
            wr_state     = e[6:3];
            wr_pi        = e[2:0];
            wr_exp_state = f_next(e[6:3], e[2:0], 1'b0);
            wr_exp_po    = g_po(e[6:3], e[2:0], 1'b0) ^ ((i == corrupt) ? 2'b01 : 2'b00);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int predict_fails();
        int n = 0;
        for (int i = 0; i < V; i++) begin
            if (f_next(cur_state[i], cur_pi[i], flt_ff) != f_next(cur_state[i], cur_pi[i], 1'b0) ||
                g_po(cur_state[i], cur_pi[i], flt_po) != g_po(cur_state[i], cur_pi[i], 1'b0))
                n++;
        end
        return n;
    endfunction

    // Start a run and check every cycle of its timeline and the result
    task automatic run_check(input int exp_cnt, input int mid_start);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int c = 0; c < T; c++) begin
            int seg = c / (N + 1);
            int off = c % (N + 1);
            logic e_tst, e_si;
            logic [PIW-1:0] e_pi;
            if (seg < V && off < N) begin
                e_tst = 1'b0; e_si = cur_state[seg][N-1-off]; e_pi = '0;
            end else if (seg < V) begin
                e_tst = 1'b1; e_si = 1'b0; e_pi = cur_pi[seg];
            end else begin
                e_tst = 1'b0; e_si = 1'b0; e_pi = '0;
            end
            chk(busy == 1'b1, "R2 busy during run", int'(busy), 1);
            chk(tst_mode == e_tst, (seg < V) ? "R3 tst_mode" : "R5 tst_mode", int'(tst_mode), int'(e_tst));
            chk(scan_in == e_si, (seg < V) ? "R3 scan_in" : "R5 filler", int'(scan_in), int'(e_si));
            chk(pi_drive == e_pi, "R4 pi_drive", int'(pi_drive), int'(e_pi));
            start = (c == mid_start);   // R9: start while busy
            @(negedge clk);
        end
        start = 1'b0;
        chk(done == 1'b1 && busy == 1'b0, "R2 done after run", int'(done), 1);
        chk(int'(fail_count) == exp_cnt, "R8 fail_count", int'(fail_count), exp_cnt);
        chk(fail == (exp_cnt != 0), "R8 fail flag", int'(fail), int'(exp_cnt != 0));
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R2 done single pulse", int'(done), 0);
    endtask

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(tst_mode == 1'b1, "R1 tst_mode", int'(tst_mode), 1);
        chk(busy == 1'b0 && done == 1'b0, "R1 busy/done", int'(busy), 0);
        chk(fail == 1'b0 && fail_count == '0, "R1 fail", int'(fail_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tst_mode == 1'b1 && busy == 1'b0, "R1 idle after release", int'(tst_mode), 1);

        // R3 R4 R5 R6 R7: clean circuit, two tables
        load_table(1'b0, -1);
        run_check(0, -1);
        load_table(1'b1, -1);
        run_check(0, -1);

        // R6: stuck primary output
        load_table(1'b0, -1);
        flt_po = 1'b1;
        chk(predict_fails() > 0, "R6 fault visible", predict_fails(), 1);
        run_check(predict_fails(), -1);
        flt_po = 1'b0;

        // R7: stuck capture flop, seen only through the unloaded bits
        flt_ff = 1'b1;
        chk(predict_fails() > 0, "R7 fault visible", predict_fails(), 1);
        run_check(predict_fails(), -1);
        flt_ff = 1'b0;

        // R8: one wrong expected entry counts exactly one pattern
        load_table(1'b0, 2);
        run_check(1, -1);

        // R8: a new run clears the previous result
        load_table(1'b0, -1);
        run_check(0, -1);

        // R9: start pulse in the middle of a run
        run_check(0, 7);

        // R10: reset in the middle of a run
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(tst_mode == 1'b1 && busy == 1'b0, "R10 idle after reset", int'(busy), 0);
        begin
            int seen = 0;
            for (int c = 0; c < T + 4; c++) begin
                @(negedge clk);
                if (done || busy) seen++;
            end
            chk(seen == 0, "R10 no done after abort", seen, 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule